// File: doc/BRIEF.md
# Edge-Framed Parallel Burst Sender

This block pushes a burst of words onto a parallel bus of 1, 2, 4, 8, 16 or 32 lines. No clock travels with the data. A single framing line tells the far end that a burst is starting, and the direction of its transition names the frame type: a rising transition opens a command frame and a falling transition opens a data frame. After that transition the block waits a programmable number of pad clocks, so the receiver has time to arm its sampler. It then presents one word per transfer. Each word is held for a programmable number of system clocks.

Words come from a ready/valid source, one word per transfer, and only the low lanes chosen by the width mode are used. The framing level and the word count, lane mode, bit period and pad are captured when a start is accepted. A one-clock done pulse closes the burst. An optional output register stage delays the bus and the framing line by the same amount, so the gap between the two does not change.

Top module: `pstream_tx`

## Requirements
- R1: After reset, sig_out, bus_out, busy, done and in_ready are all 0.
- R2: On an accepted start, sig_out moves to the level given by frame_cmd (1 = command frame, which gives a rising transition; 0 = data frame, which gives a falling transition) on the accepting clock edge. If sig_out already sits at that level, it first spends exactly one clock at the opposite level, so the named transition always occurs one clock later.
- R3: The first word reaches bus_out exactly pad_clks+1 clocks after the clock edge that produced the framing transition.
- R4: Width mode m (0..5) drives lanes bus_out[2^m-1:0] from the same bits of the input word, and holds every higher lane at 0.
- R5: Each word stays on bus_out for clks_per_bit clocks. Settings 0 and 1 both mean one clock, and odd settings such as 3 are honoured exactly.
- R6: A burst consumes exactly word_count words from the source, in arrival order. in_ready is high only in the clock whose closing edge loads the next word.
- R7: After the final word of a burst, bus_out keeps that word until a later burst loads a new one.
- R8: done is a one-clock pulse. It rises on the edge where the final word's hold time expires, and busy falls on that same edge.
- R9: A start that arrives while busy is high is ignored. The running burst keeps its captured settings and its timing.
- R10: With word_count 0, no word is taken, bus_out keeps its value, and done rises pad_clks+1 clocks after the framing transition.
- R11: With REG_OUT = 1, bus_out and sig_out each lag the unregistered version by exactly one clock, while done and busy keep their timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a burst when idle |
| frame_cmd | input | 1 | 1 = command frame (rising), 0 = data frame (falling) |
| word_count | input | CNT_W | Number of words in the burst |
| width_mode | input | 3 | Lane count select, 2^mode lanes, 0..5 |
| clks_per_bit | input | PER_W | System clocks each word is held |
| pad_clks | input | PAD_W | Clocks between framing transition and first word, minus one |
| in_data | input | DW | Source word |
| in_valid | input | 1 | Source word is valid |
| in_ready | output | 1 | Block takes the source word at the next edge |
| bus_out | output | DW | Parallel data lanes |
| sig_out | output | 1 | Framing line |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-clock end-of-burst pulse |

## Verification
A timer that is off by one shows up directly as a word edge shifted by one clock. The shift appears at the first word when it comes from the pad count, and it repeats on every word when it comes from the hold time, so a per-clock comparison catches it within one bit period. A wrong remaining-word count shows up at the end of the burst. The bus then either changes one time too many, or done arrives a full hold period early or late, and the running tally of source handshakes disagrees. A wrong captured framing level shows up on the first clock as a transition in the wrong direction, or as a missing return cycle.

// File: rtl/pstream_tx.sv
module pstream_tx #(
  parameter int DW      = 32,
  parameter int CNT_W   = 16,
  parameter int PER_W   = 8,
  parameter int PAD_W   = 4,
  parameter bit REG_OUT = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             frame_cmd,
  input  logic [CNT_W-1:0] word_count,
  input  logic [2:0]       width_mode,
  input  logic [PER_W-1:0] clks_per_bit,
  input  logic [PAD_W-1:0] pad_clks,
  input  logic [DW-1:0]    in_data,
  input  logic             in_valid,
  output logic             in_ready,
  output logic [DW-1:0]    bus_out,
  output logic             sig_out,
  output logic             busy,
  output logic             done
);
  localparam int TW = (PER_W > PAD_W) ? PER_W : PAD_W;

  typedef enum logic [1:0] {IDLE, FLIP, PAD, XFER} st_t;
  st_t st;

  logic [TW-1:0]    tmr;
  logic [CNT_W-1:0] left;
  logic [PER_W-1:0] per_l;
  logic [PAD_W-1:0] pad_l;
  logic [DW-1:0]    mask_l, bus_q;
  logic             tgt_l, sig_q;

  function automatic logic [DW-1:0] lane_mask(input logic [2:0] m);
    logic [6:0] n;
    n = 7'd1 << m;
    if (m >= 3'd5 || int'(n) >= DW) return '1;
    return (DW'(1) << n) - DW'(1);
  endfunction

  wire [TW-1:0] hold_ld = (per_l == '0) ? '0 : TW'(per_l - PER_W'(1));
  wire          slot    = (tmr == '0);

  assign busy     = (st != IDLE);
  assign in_ready = slot && ((st == PAD) || (st == XFER)) && (left != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; tmr <= '0; left <= '0; per_l <= '0; pad_l <= '0;
      mask_l <= '0; bus_q <= '0; tgt_l <= 1'b0; sig_q <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        IDLE: if (start) begin
          tgt_l  <= frame_cmd;
          left   <= word_count;
          per_l  <= clks_per_bit;
          pad_l  <= pad_clks;
          mask_l <= lane_mask(width_mode);
          tmr    <= TW'(pad_clks);
          sig_q  <= (sig_q == frame_cmd) ? ~frame_cmd : frame_cmd;
          st     <= (sig_q == frame_cmd) ? FLIP : PAD;
        end
        FLIP: begin
          sig_q <= tgt_l;
          tmr   <= TW'(pad_l);
          st    <= PAD;
        end
        default: begin
          if (!slot) tmr <= tmr - TW'(1);
          else if (left == '0) begin
            done <= 1'b1;
            st   <= IDLE;
          end else if (in_valid) begin
            bus_q <= in_data & mask_l;
            left  <= left - CNT_W'(1);
            tmr   <= hold_ld;
            st    <= XFER;
          end
        end
      endcase
    end
  end

  generate
    if (REG_OUT) begin : g_reg
      logic [DW-1:0] bus_r;
      logic          sig_r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin bus_r <= '0; sig_r <= 1'b0; end
        else begin bus_r <= bus_q; sig_r <= sig_q; end
      end
      assign bus_out = bus_r;
      assign sig_out = sig_r;
    end else begin : g_dir
      assign bus_out = bus_q;
      assign sig_out = sig_q;
    end
  endgenerate

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_READY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> busy); // R6
  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && in_valid) |=> $stable(bus_q)); // R7
  AST_SIG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(sig_q)); // R2
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && st != FLIP) |=> $stable(tgt_l) && $stable(mask_l)); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R8
endmodule

// File: tb/pstream_tx_test.sv
module pstream_tx_test;
  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic        start = 0, frame_cmd = 0, in_valid = 1;
  logic [15:0] word_count = 0;
  logic [2:0]  width_mode = 0;
  logic [7:0]  clks_per_bit = 0;
  logic [3:0]  pad_clks = 0;
  logic [31:0] in_data;
  logic        in_ready, sig_out, busy, done, in_ready_r, sig_r, busy_r, done_r;
  logic [31:0] bus_out, bus_r;

  pstream_tx uut (.clk, .rst_n, .start, .frame_cmd, .word_count, .width_mode,
    .clks_per_bit, .pad_clks, .in_data, .in_valid, .in_ready, .bus_out,
    .sig_out, .busy, .done);
  pstream_tx #(.REG_OUT(1)) uut_r (.clk, .rst_n, .start, .frame_cmd, .word_count,
    .width_mode, .clks_per_bit, .pad_clks, .in_data, .in_valid,
    .in_ready(in_ready_r), .bus_out(bus_r), .sig_out(sig_r), .busy(busy_r), .done(done_r));

  int checks = 0, errors = 0, k = 0, cyc = 0;
  bit took = 0;

  function automatic logic [31:0] pat(input int i);
    return (32'(i) * 32'h9E3779B1) ^ (32'(i) << 7) ^ 32'h5A5A0F0F;
  endfunction
  function automatic logic [31:0] mk(input int m);
    return (m >= 5) ? 32'hFFFF_FFFF : ((32'd1 << (1 << m)) - 32'd1);
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(negedge clk) begin
    if (took) k++;
    in_data = pat(k);
    took = in_ready;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog got %0d expected <150000", cyc);
      finish_run();
    end
  end

  task automatic run_frame(input bit cmd, input int m, input int per, input int pad,
                           input int cnt, input bit poke);
    bit pre; int e, p, t0, td, base, j;
    logic [31:0] pb, eb, ps_bus; logic ps_sig;
    pre = (sig_out == cmd); e = pre ? 2 : 1; p = (per == 0) ? 1 : per;
    t0 = e + pad + 1; td = t0 + cnt * p; pb = bus_out; base = k;
    ps_bus = bus_out; ps_sig = sig_out;
    frame_cmd = cmd; width_mode = 3'(m); clks_per_bit = 8'(per);
    pad_clks = 4'(pad); word_count = 16'(cnt); start = 1;
    for (int t = 1; t <= td + 1; t++) begin
      @(negedge clk);
      chk("R2 sig", {31'd0, sig_out}, {31'd0, (pre && t == 1) ? ~cmd : cmd});
      if (t < t0 || cnt == 0) eb = pb;
      else begin
        j = (t - t0) / p; if (j > cnt - 1) j = cnt - 1;
        eb = pat(base + j) & mk(m);
      end
      chk(t < t0 ? "R3 bus before first word" : (t >= td ? "R7 bus hold" : "R5 R4 bus word"), bus_out, eb);
      chk(cnt == 0 ? "R10 done" : "R8 done", {31'd0, done}, {31'd0, t == td});
      chk("R8 busy", {31'd0, busy}, {31'd0, t < td});
      chk("R11 sig lag", {31'd0, sig_r}, {31'd0, ps_sig});
      chk("R11 bus lag", bus_r, ps_bus);
      chk("R11 done", {31'd0, done_r}, {31'd0, done});
      ps_sig = sig_out; ps_bus = bus_out;
      if (t == 1) start = 0;
      if (poke && t == 2 && td > 3) begin
        start = 1; frame_cmd = ~cmd; width_mode = 3'd5; clks_per_bit = 8'd1;
        pad_clks = 4'd0; word_count = 16'd7;
      end
      if (t == 3) start = 0;
    end
    chk(cnt == 0 ? "R10 words taken" : "R6 words taken", 32'(k - base), 32'(cnt));
    chk("R9 idle after", {31'd0, busy}, 32'd0);
  endtask

  initial begin
    int pers[5] = '{0, 1, 2, 3, 4};
    int pads[3] = '{0, 2, 3};
    int cnts[3] = '{0, 1, 3};
    int n = 0;
    #35;
    chk("R1 sig", {31'd0, sig_out}, 32'd0);
    chk("R1 bus", bus_out, 32'd0);
    chk("R1 busy done ready", {29'd0, busy, done, in_ready}, 32'd0);
    rst_n = 1;
    @(negedge clk);
    for (int m = 0; m < 6; m++)
      for (int a = 0; a < 5; a++)
        for (int b = 0; b < 3; b++)
          for (int c = 0; c < 3; c++) begin
            run_frame(((n % 3) != 1), m, pers[a], pads[b], cnts[c], (n % 4) == 0);
            n++;
          end
    run_frame(1, 5, 1, 0, 32, 1);
    finish_run();
  end
endmodule